// File: doc/BRIEF.md
# PCI Bridge Interrupt Pending and Enable Register

This block gathers the four active-low PCI INTx# request lines and six bus error events of a PCI host bridge into one 32-bit word. The lower half of the word shows what is pending. The upper half holds an enable bit for each pending bit, at the same position moved up by 16. Any pending bit whose enable is set drives the single combined interrupt line toward the system interrupt controller. Error-detection logic elsewhere in the bridge supplies the error events as one-cycle pulses.

The host programs the word through a write port. Each write loads the whole enable field. It also clears the error flags that have a 1 in their position of the written data. A write of all zeros disables every source and drops all sticky state. The INTx# flags are not stored: they follow the synchronized line levels. The full word is always visible on a read port.

The write port uses a valid/ready handshake. `wr_ready` is held high, so the block never applies back-pressure. A beat is accepted on any rising edge where `wr_valid` is high. It acts on the register only when `wr_addr` equals the register's offset. Beats to any other offset are accepted and discarded.

Top module: `pci_irq_status`

## Requirements
- R1: After reset, `rd_data` reads 32'h00E0_0000 and `irq` is low. In this state the enables are set for received master abort, received target abort and signalled target abort, and all pending flags are clear.
- R2: Pending bits are laid out as follows. Bits 3..0 are INTA#..INTD#. Bit 4 is data parity error detected, bit 5 signalled target abort, bit 6 received target abort, bit 7 received master abort, bit 8 signalled system error and bit 9 detected parity error. `err_evt[k]` feeds pending bit 4+k. The enable for pending bit i sits at bit 16+i.
- R3: INTx pending bit n is the inverse of `intx_n[n]`, delayed by two rising edges through a synchronizer. It is not sticky, and writes have no effect on it.
- R4: An error pending bit is set at the rising edge where its `err_evt` bit is high. It then stays set until a write clears it.
- R5: An accepted write with nonzero data clears each error pending bit that has a 1 at its position in `wr_data`. An event that arrives in the same cycle as its clear leaves the bit set.
- R6: An accepted write loads `wr_data[25:16]` into the enable field at that edge. With no accepted write, the enable field holds its value.
- R7: An accepted write of 32'h0 clears every enable bit and every error pending bit.
- R8: `irq` is high exactly when some pending bit in `rd_data[9:0]` has its enable bit set, and it is valid in the same cycle as `rd_data`.
- R9: Bits 15:10 and 31:26 always read as zero, whatever is written to them.
- R10: `wr_ready` is always high. A beat whose `wr_addr` differs from REG_OFFSET (default 8'h1C) leaves `rd_data` unchanged.
- R11: With PARITY_DETECT=0, the enable bits for pending bits 4, 8 and 9 (bits 20, 24, 25) are fixed at zero. Writes cannot set them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_n | input | 4 | PCI INTA#..INTD# request levels, active low, asynchronous |
| err_evt | input | 6 | One-cycle error event pulses, bit k sets pending bit 4+k |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready, always high |
| wr_addr | input | ADDR_W | Register offset of the write beat |
| wr_data | input | 32 | Write data: enables in 25:16, clear-by-one flags in 9:4 |
| rd_data | output | 32 | Full register: enables in 25:16, pending in 9:0 |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `err_evt` and the write port are synchronous to `clk` and carry known values. They also assume that the error sources use `err_evt` only as a pulse, so a bit held high simply sets its flag again on each cycle. Only `intx_n` may change asynchronously. The stimulus drives every input between clock edges. It keeps error pulses sparse, so that set, hold and clear-by-one are each observed on their own. It also forces same-cycle set-and-clear, all-zero writes and beats to a wrong offset as directed cases.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int unsigned N_INTX   = 4;
  localparam int unsigned N_ERR    = 6;
  localparam int unsigned N_SRC    = N_INTX + N_ERR;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned HALF_W   = REG_W / 2;
  localparam int unsigned ENA_LSB  = HALF_W;
  localparam int unsigned ERR_LSB  = N_INTX;
  localparam int unsigned RSV_W    = HALF_W - N_SRC;

  typedef logic [N_SRC-1:0] src_vec_t;
  typedef logic [N_ERR-1:0] err_vec_t;

  // Error sources whose detection may be absent in a given bridge.
  localparam src_vec_t OPTIONAL_SRC = src_vec_t'(10'b11_0001_0000);
  localparam src_vec_t DEFAULT_ENA  = src_vec_t'(10'b00_1110_0000);

  function automatic logic [REG_W-1:0] pack_word(src_vec_t ena, src_vec_t pend);
    return {{RSV_W{1'b0}}, ena, {RSV_W{1'b0}}, pend};
  endfunction
endpackage

// File: rtl/pci_irq_sync.sv
module pci_irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= IDLE;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pci_irq_err_latch.sv
module pci_irq_err_latch #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;

  // A set in the same cycle as a clear wins, so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pci_irq_ena_reg.sv
module pci_irq_ena_reg #(
  parameter int unsigned WIDTH = 10,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter logic [WIDTH-1:0] WRITABLE  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
    if (WRITABLE[i]) begin : g_rw
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= RESET_VAL[i];
        else if (load_i) bit_q <= d_i[i];
      end
      assign q_o[i] = bit_q;
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pci_irq_status.sv
module pci_irq_status
  import pci_irq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h1C),
  parameter bit          PARITY_DETECT = 1'b1,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INTX-1:0] intx_n,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  localparam src_vec_t ENA_WRITABLE = PARITY_DETECT ? '1 : ~OPTIONAL_SRC;
  localparam src_vec_t ENA_RESET    = DEFAULT_ENA & ENA_WRITABLE;

  logic              wr_hit;
  logic              wr_zero;
  logic [N_INTX-1:0] intx_sync_n;
  err_vec_t          err_clr;
  err_vec_t          err_flag;
  src_vec_t          ena;
  src_vec_t          pend;

  assign wr_ready = 1'b1;
  assign wr_hit   = wr_valid && (wr_addr == REG_OFFSET);
  assign wr_zero  = (wr_data == '0);

  always_comb begin
    err_clr = '0;
    if (wr_hit) err_clr = wr_zero ? '1 : wr_data[ERR_LSB +: N_ERR];
  end

  pci_irq_sync #(
    .WIDTH (N_INTX),
    .STAGES(SYNC_STAGES),
    .IDLE  ('1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (intx_n),
    .dout (intx_sync_n)
  );

  pci_irq_err_latch #(
    .WIDTH(N_ERR)
  ) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_evt),
    .clr_i (err_clr),
    .flag_o(err_flag)
  );

  pci_irq_ena_reg #(
    .WIDTH    (N_SRC),
    .RESET_VAL(ENA_RESET),
    .WRITABLE (ENA_WRITABLE)
  ) u_ena (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(wr_hit),
    .d_i   (wr_data[ENA_LSB +: N_SRC]),
    .q_o   (ena)
  );

  assign pend    = {err_flag, ~intx_sync_n};
  assign rd_data = pack_word(ena, pend);
  assign irq     = |(pend & ena);
endmodule

// File: rtl/pci_irq_status_chk.sv
module pci_irq_status_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h1C),
  parameter bit PARITY_DETECT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        err_evt,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              irq
);
  localparam logic [9:0] ALLOW = PARITY_DETECT ? 10'h3FF : 10'h0EF;

  logic hit;
  assign hit = wr_valid && (wr_addr == REG_OFFSET);

  AST_IRQ_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(rd_data[9:0] & rd_data[25:16])); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:10] == 6'd0 && rd_data[31:26] == 6'd0); // R9

  AST_ENA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rd_data[25:16] == ($past(wr_data[25:16]) & ALLOW)); // R6

  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(rd_data[25:16])); // R10

  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_data == 32'd0 && err_evt == 6'd0) |=> rd_data[25:4] == 22'd0); // R7

  AST_ENA_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[25:16] & ~ALLOW) == 10'd0); // R11

  for (genvar k = 0; k < 6; k++) begin : g_err
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt[k] |=> rd_data[4+k]); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[4+k] && !hit) |=> rd_data[4+k]); // R4

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_data[4+k] && !err_evt[k]) |=> !rd_data[4+k]); // R5
  end
endmodule

bind pci_irq_status pci_irq_status_chk #(
  .ADDR_W       (ADDR_W),
  .REG_OFFSET   (REG_OFFSET),
  .PARITY_DETECT(PARITY_DETECT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .err_evt (err_evt),
  .wr_valid(wr_valid),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq     (irq)
);

// File: tb/test_pci_irq_status.sv
`timescale 1ns/1ps
module test_pci_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_n = 4'hF;
  logic [5:0]  err_evt = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = 8'h1C;
  logic [31:0] wr_data = '0;
  logic        wr_ready, wr_ready_np;
  logic [31:0] rd_data, rd_data_np;
  logic        irq, irq_np;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pci_irq_status i_pci_irq_status (
    .clk(clk), .rst_n(rst_n), .intx_n(intx_n), .err_evt(err_evt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  pci_irq_status #(.PARITY_DETECT(1'b0)) i_pci_irq_status_np (
    .clk(clk), .rst_n(rst_n), .intx_n(intx_n), .err_evt(err_evt),
    .wr_valid(wr_valid), .wr_ready(wr_ready_np), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data_np), .irq(irq_np)
  );

  // Reference state, one set per instance.
  logic [3:0] m_s1, m_s2;
  logic [5:0] m_err;
  logic [9:0] m_ena, m_ena_np;

  function automatic logic [31:0] exp_word(logic [9:0] ena, logic [5:0] err, logic [3:0] s2);
    return {6'd0, ena, 6'd0, err, ~s2};
  endfunction

  function automatic logic exp_irq(logic [31:0] w);
    return |(w[9:0] & w[25:16]);
  endfunction

  task automatic model_reset();
    m_s1 = 4'hF; m_s2 = 4'hF; m_err = '0;
    m_ena = 10'h0E0; m_ena_np = 10'h0E0;
  endtask

  task automatic model_edge();
    logic hit;
    logic [5:0] clr;
    hit = wr_valid && wr_addr == 8'h1C;
    clr = !hit ? 6'd0 : (wr_data == 0 ? 6'h3F : wr_data[9:4]);
    m_err = (m_err & ~clr) | err_evt;
    if (hit) begin
      m_ena    = wr_data[25:16];
      m_ena_np = wr_data[25:16] & 10'h0EF;
    end
    m_s2 = m_s1;
    m_s1 = intx_n;
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #5;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic idle();
    wr_valid = 1'b0; err_evt = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1", rd_data, 32'h00E0_0000);
    check("R1", {31'd0, irq}, 32'd0);
    check("R11", rd_data_np, 32'h00E0_0000);
    check("R10", {31'd0, wr_ready}, 32'd1);

    // R3 INTC# low: two-edge latency
    intx_n = 4'b1011;
    step(); check("R3", rd_data, 32'h00E0_0000);
    step(); check("R3", rd_data, 32'h00E0_0004);
    check("R8", {31'd0, irq}, 32'd0);

    // R6 enable INTC
    wr(8'h1C, 32'h00E4_0000);
    step(); idle();
    check("R6", rd_data, 32'h00E4_0004);
    check("R8", {31'd0, irq}, 32'd1);

    // R3 not sticky
    intx_n = 4'hF;
    step(); check("R3", rd_data, 32'h00E4_0004);
    step(); check("R3", rd_data, 32'h00E4_0000);
    check("R8", {31'd0, irq}, 32'd0);

    // R4 received target abort (bit 6) sticky
    err_evt = 6'b000100;
    step(); idle();
    check("R4", rd_data, 32'h00E4_0040);
    check("R8", {31'd0, irq}, 32'd1);
    step(); step();
    check("R4", rd_data, 32'h00E4_0040);

    // data parity detected (bit 4), masked
    err_evt = 6'b000001;
    step(); idle();
    check("R2", rd_data, 32'h00E4_0050);

    // R10 wrong offset ignored
    wr(8'h18, 32'h0);
    step(); idle();
    check("R10", rd_data, 32'h00E4_0050);

    // R5 clear bit 6 only
    wr(8'h1C, 32'h00E4_0040);
    step(); idle();
    check("R5", rd_data, 32'h00E4_0010);
    check("R8", {31'd0, irq}, 32'd0);

    // R5 set wins over clear on bit 7
    err_evt = 6'b001000;
    wr(8'h1C, 32'h00E4_0080);
    step(); idle();
    check("R5", rd_data, 32'h00E4_0090);
    check("R8", {31'd0, irq}, 32'd1);

    // R9 reserved bits ignore writes
    wr(8'h1C, 32'hFCE4_FC00);
    step(); idle();
    check("R9", rd_data, 32'h00E4_0090);

    // R7 zero write
    wr(8'h1C, 32'h0);
    step(); idle();
    check("R7", rd_data, 32'h0);
    check("R7", {31'd0, irq}, 32'd0);

    // R11 optional enables fixed at zero
    wr(8'h1C, 32'h03FF_0000);
    step(); idle();
    check("R6", rd_data, 32'h03FF_0000);
    check("R11", rd_data_np, 32'h00EF_0000);
    err_evt = 6'b100000;
    step(); idle();
    check("R2", rd_data, 32'h03FF_0200);
    check("R11", rd_data_np, 32'h00EF_0200);
    check("R11", {31'd0, irq_np}, 32'd0);

    // Random phase against the reference model
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4000; n++) begin
      intx_n  = ($urandom % 4 == 0) ? 4'($urandom) : intx_n;
      err_evt = ($urandom % 8 == 0) ? 6'(1 << ($urandom % 6)) : 6'd0;
      wr_valid = ($urandom % 4 == 0);
      wr_addr  = ($urandom % 8 == 0) ? 8'($urandom) : 8'h1C;
      case ($urandom % 6)
        0:       wr_data = 32'h0;
        1:       wr_data = {16'($urandom), 16'h0};
        default: wr_data = $urandom;
      endcase
      step();
      check("R2", rd_data, exp_word(m_ena, m_err, m_s2));
      check("R8", {31'd0, irq}, {31'd0, exp_irq(exp_word(m_ena, m_err, m_s2))});
      check("R11", rd_data_np, exp_word(m_ena_np, m_err, m_s2));
      check("R8", {31'd0, irq_np}, {31'd0, exp_irq(exp_word(m_ena_np, m_err, m_s2))});
    end
    idle();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule